// File: doc/BRIEF.md
# System Tick Down Counter

A periodic timer built on a 24-bit down counter. Software sets a reload value, clears the counter, and enables counting. The counter decrements once per tick of the selected clock. When it steps from 1 to 0 it latches a sticky count flag and, if enabled, emits a one-cycle interrupt pulse. On the next tick it reloads, so the period is the reload value plus one ticks. A tick comes either from every core clock cycle or from each rising edge of a slower external reference, which is first brought into the core clock domain.

Three word registers sit on a plain register bus: control/status, reload, and current value.
- **Requests:** a request is accepted in every cycle it is presented. There is no ready signal and no back-pressure.
- **Reads:** read data comes back registered, one cycle after the request, qualified by a valid strobe.
- **Acknowledging a tick:** software reads the control register. That read returns the count flag and clears it.

Top module: `tick_timer`

## Requirements
- R1: After reset the control register reads 0x0000_0004 (core clock selected, counter and interrupt disabled, flag clear). The reload and current-value registers read 0, and `irq_o` is low.
- R2: While control bit 0 (enable) is 1, the counter decrements by one on each selected tick. While bit 0 is 0, the counter holds its value.
- R3: A tick that finds the counter at 0 loads the reload value, so with a nonzero reload the 1-to-0 step repeats every reload+1 ticks.
- R4: On each 1-to-0 step the count flag (control bit 16) is set. If control bit 1 (interrupt enable) is 1, `irq_o` is high for exactly one cycle, in the cycle after that step.
- R5: With control bit 1 at 0, the 1-to-0 step still sets the count flag, but `irq_o` stays low.
- R6: A read of the control register returns the flag as it stood and clears it. A 1-to-0 step in the same cycle leaves the flag set.
- R7: Any write to the current-value register forces the counter to 0 and clears the flag, without an interrupt. The written data is ignored.
- R8: Control bit 2 chooses the tick source: 1 selects the core clock, 0 selects the external reference. The external reference passes through a two-flop synchronizer, and each of its rising edges gives exactly one tick.
- R9: With a reload value of 0 the counter stays at 0. The flag is never set and `irq_o` never rises.
- R10: Register byte offsets are 0x0 for control, 0x4 for reload and 0x8 for current value; any other offset reads 0.
  - Reload and current value occupy bits 23:0, and bits 31:24 read 0.
  - Read data and `bus_rvalid_o` appear in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | External reference clock, asynchronous to clk_i |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the request |
| bus_rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | One-cycle tick interrupt pulse |

## Verification
A wrong counter value shows up on the current-value register as soon as the counter is stopped and read. It also shows as an `irq_o` spacing that differs from reload+1 cycles, which is visible within one period. A flag that fails to set, or fails to clear, is exposed by the very next control read. A lost or doubled external edge shifts the stopped count by one, a few cycles after the reference pulses stop.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_IE_BIT   = 1;
  localparam int CTRL_SRC_BIT  = 2;
  localparam int CTRL_FLAG_BIT = 16;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_VALUE  = 4'h8;

  typedef struct packed {
    logic src;  // 1 = core clock, 0 = external reference
    logic ie;
    logic en;
  } tick_ctrl_t;
endpackage

// File: rtl/tick_sync.sv
module tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic rise_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], ref_i};
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

  // R8: one synchronized edge gives a single tick
  p_single_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tick_core.sv
module tick_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_evt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (tick_i) begin
      if (cnt_q == '0)    cnt_q <= reload_i;
      else                cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_o      = cnt_q;
  assign zero_evt_o = tick_i & ~clr_i & (cnt_q == ONE);

  p_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && cnt_q == '0) |=> cnt_q == $past(reload_i));
  p_decrement_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              zero_evt_i,
  output tick_ctrl_t        ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              clr_o,
  output logic              flag_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  tick_ctrl_t        ctrl_q;
  logic [CNT_W-1:0]  reload_q;
  logic              flag_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic              wr_ctrl, wr_reload, rd_req, rd_ctrl;

  assign wr_ctrl   = req_i & we_i & (addr_i == OFS_CTRL);
  assign wr_reload = req_i & we_i & (addr_i == OFS_RELOAD);
  assign clr_o     = req_i & we_i & (addr_i == OFS_VALUE);
  assign rd_req    = req_i & ~we_i;
  assign rd_ctrl   = rd_req & (addr_i == OFS_CTRL);

  generate
    if (CNT_W < DATA_W) begin : g_spare
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata_i[DATA_W-1:CNT_W];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '{src: 1'b1, ie: 1'b0, en: 1'b0};
      reload_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en  <= wdata_i[CTRL_EN_BIT];
        ctrl_q.ie  <= wdata_i[CTRL_IE_BIT];
        ctrl_q.src <= wdata_i[CTRL_SRC_BIT];
      end
      if (wr_reload) reload_q <= wdata_i[CNT_W-1:0];
    end
  end

  // sticky flag: a new zero step wins over a clearing access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 flag_q <= 1'b0;
    else if (zero_evt_i)         flag_q <= 1'b1;
    else if (rd_ctrl || clr_o)   flag_q <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      OFS_CTRL: begin
        rd_mux[CTRL_EN_BIT]   = ctrl_q.en;
        rd_mux[CTRL_IE_BIT]   = ctrl_q.ie;
        rd_mux[CTRL_SRC_BIT]  = ctrl_q.src;
        rd_mux[CTRL_FLAG_BIT] = flag_q;
      end
      OFS_RELOAD: rd_mux = DATA_W'(reload_q);
      OFS_VALUE:  rd_mux = DATA_W'(cnt_i);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_req;
      rdata_q  <= rd_req ? rd_mux : '0;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
  assign flag_o   = flag_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  p_flag_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_evt_i |=> flag_q);
  p_flag_rdclr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ctrl && !zero_evt_i) |=> !flag_q);
  p_rvalid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rvalid_q);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_clk_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic              irq_o
);
  tick_ctrl_t       ctrl;
  logic [CNT_W-1:0] reload, cnt;
  logic             clr, flag, ext_rise, tick, zero_evt, irq_q;

  tick_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i), .rst_ni(rst_ni), .ref_i(ref_clk_i), .rise_o(ext_rise)
  );

  tick_regs #(.CNT_W(CNT_W)) regs_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(bus_req_i), .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .cnt_i(cnt), .zero_evt_i(zero_evt),
    .ctrl_o(ctrl), .reload_o(reload), .clr_o(clr), .flag_o(flag),
    .rdata_o(bus_rdata_o), .rvalid_o(bus_rvalid_o)
  );

  assign tick = ctrl.en & (ctrl.src | ext_rise);

  tick_core #(.CNT_W(CNT_W)) core_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .clr_i(clr),
    .reload_i(reload), .cnt_o(cnt), .zero_evt_o(zero_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= zero_evt & ctrl.ie;
  end

  assign irq_o = irq_q;

  p_irq_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  p_irq_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> flag);
  p_zero_reload_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload == '0 && cnt == '0) |=> cnt == '0);
  p_ext_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.en && !ctrl.src && !ext_rise && !clr) |=> $stable(cnt));
endmodule

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_clk = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;

  localparam logic [3:0] A_CTRL = 4'h0, A_RELOAD = 4'h4, A_VALUE = 4'h8;
  localparam logic [23:0] VEC_RELOAD [4] = '{24'd1, 24'd2, 24'd5, 24'd17};
  localparam int          VEC_PERIOD [4] = '{2, 3, 6, 18};

  always #5 clk = ~clk;

  tick_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .bus_rvalid_o(bus_rvalid), .irq_o(irq)
  );

  always @(negedge clk) if (irq) irq_seen++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // callers stand at a negedge; each access takes one cycle
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    int s;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(A_CTRL, d);   chk("R1 ctrl", d, 32'h4);
    rd(A_RELOAD, d); chk("R1 reload", d, 32'h0);
    rd(A_VALUE, d);  chk("R1 value", d, 32'h0);

    // R3/R4/R6 table walk: period, pulse width, flag read-clear
    for (int i = 0; i < 4; i++) begin
      wr(A_CTRL, 32'h4);
      wr(A_RELOAD, 32'(VEC_RELOAD[i]));
      wr(A_VALUE, 32'h0);
      rd(A_CTRL, d);
      wr(A_CTRL, 32'h7);
      for (int k = 0; k < 100 && !irq; k++) @(negedge clk);
      @(negedge clk);
      chk("R4 pulse width", {31'b0, irq}, 32'h0);
      n = 1;
      while (!irq && n < 200) begin @(negedge clk); n++; end
      chk("R3 period", n, VEC_PERIOD[i]);
      wr(A_CTRL, 32'h6);
      rd(A_CTRL, d); chk("R4 flag set", d, 32'h0001_0006);
      rd(A_CTRL, d); chk("R6 flag cleared by read", d, 32'h6);
    end

    // R2 decrement and hold
    wr(A_CTRL, 32'h4);
    wr(A_RELOAD, 32'd10);
    wr(A_VALUE, 32'h0);
    wr(A_CTRL, 32'h5);
    repeat (3) @(negedge clk);
    wr(A_CTRL, 32'h4);
    rd(A_VALUE, d); chk("R2 count after 4 ticks", d, 32'd7);
    repeat (5) @(negedge clk);
    rd(A_VALUE, d); chk("R2 hold while disabled", d, 32'd7);

    // R5 flag without interrupt
    wr(A_RELOAD, 32'd3);
    wr(A_VALUE, 32'h0);
    rd(A_CTRL, d);
    s = irq_seen;
    wr(A_CTRL, 32'h5);
    repeat (20) @(negedge clk);
    wr(A_CTRL, 32'h4);
    chk("R5 no irq", irq_seen, s);
    rd(A_CTRL, d); chk("R5 flag set", d, 32'h0001_0004);

    // R7 value write clears counter and flag, no interrupt
    wr(A_VALUE, 32'h0);
    wr(A_CTRL, 32'h7);
    repeat (10) @(negedge clk);
    wr(A_CTRL, 32'h6);
    s = irq_seen;
    wr(A_VALUE, 32'h0000_0123);
    repeat (5) @(negedge clk);
    chk("R7 no irq", irq_seen, s);
    rd(A_VALUE, d); chk("R7 value cleared", d, 32'h0);
    rd(A_CTRL, d);  chk("R7 flag cleared", d, 32'h6);

    // R9 zero reload
    wr(A_RELOAD, 32'h0);
    wr(A_VALUE, 32'h0);
    s = irq_seen;
    wr(A_CTRL, 32'h7);
    repeat (30) @(negedge clk);
    wr(A_CTRL, 32'h6);
    chk("R9 no irq", irq_seen, s);
    rd(A_VALUE, d); chk("R9 value stays 0", d, 32'h0);
    rd(A_CTRL, d);  chk("R9 flag stays clear", d, 32'h6);

    // R8 external reference
    wr(A_CTRL, 32'h0);
    wr(A_RELOAD, 32'd100);
    wr(A_VALUE, 32'h0);
    wr(A_CTRL, 32'h1);
    repeat (10) @(negedge clk);
    rd(A_VALUE, d); chk("R8 no ticks without ref edges", d, 32'h0);
    for (int p = 0; p < 4; p++) begin
      ref_clk = 1'b1; repeat (3) @(negedge clk);
      ref_clk = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    wr(A_CTRL, 32'h0);
    rd(A_VALUE, d); chk("R8 four ref edges", d, 32'd97);

    // R10 map, field widths, read timing
    wr(A_RELOAD, 32'hAB12_3456);
    rd(A_RELOAD, d); chk("R10 reload width", d, 32'h0012_3456);
    chk("R10 rvalid with data", {31'b0, bus_rvalid}, 32'h1);
    @(negedge clk);
    chk("R10 rvalid drops", {31'b0, bus_rvalid}, 32'h0);
    rd(4'hC, d); chk("R10 unmapped reads 0", d, 32'h0);

    summary();
  end
endmodule